// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer loop. It takes the fast oscillator clock and produces one narrow pulse for every N input cycles. The pulse feeds the phase detector. The division follows the pulse-swallow scheme:

- A prescaler divides the input clock by either P or P+1. P is chosen from four values by a 2-bit mode field.
- A swallow counter (A) and a main counter (B) count prescaler cycles and steer the modulus.
- The resulting ratio is N = P*B + A.

The whole chain runs synchronously on the input clock.

Software presents the A, B and mode values on the input ports and pulses the load strobe. Only then does the new setting take effect. The load also restarts the division period, so the first pulse after a load comes exactly N cycles later. A setting where B is below A, or B is below three, cannot be realized. Such a setting is flagged, and the divider stays silent until a valid setting is loaded.

Top module: `psd_fb_divider`

## Requirements
- R1: The 2-bit mode selects the lower prescaler modulus P: 00 gives 8, 01 gives 16, 10 gives 32, 11 gives 64. The upper modulus is always P+1.
- R2: Any A from 0 to 63 together with any B from 3 to 8191 that satisfies B >= A is a valid setting, and `cfg_err_o` stays low for it.
- R3: With a valid setting, successive rising edges of `div_o` are exactly P*B + A input clock cycles apart.
- R4: Every output pulse is high for exactly one input clock cycle.
- R5: Values on `a_i`, `b_i` and `mode_i` have no effect unless `load_i` is high at a clock edge. Without a load, the output period stays the one last loaded.
- R6: A load restarts the period. `div_o` is low in the cycle after the load edge, and the first pulse appears N clock edges after the load edge.
- R7: A loaded setting with B < A or B < 3 drives `cfg_err_o` high and holds `div_o` and `mod_sel_o` low until a valid setting is loaded.
- R8: During and after reset, the loaded setting is A=0, B=8, mode 00, so the period is 64 cycles. During reset, `div_o`, `cfg_err_o` and `mod_sel_o` are low.
- R9: Within each period, `mod_sel_o` is high for the first A prescaler cycles, which is A*(P+1) input cycles, and low for the remaining B-A prescaler cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 6 | Swallow count to load |
| b_i | input | 13 | Main count to load |
| mode_i | input | 2 | Prescaler pair select to load |
| load_i | input | 1 | Load strobe; applies a_i, b_i, mode_i and restarts the period |
| div_o | output | 1 | Divided output pulse, one cycle wide |
| mod_sel_o | output | 1 | High while the prescaler divides by P+1 |
| cfg_err_o | output | 1 | High while the loaded setting is invalid |

## Verification
The assertions assume that `load_i` is a single-cycle strobe. They also assume that any valid period is at least a few dozen cycles long, so a pulse never falls right after a load. The bench meets both assumptions: it raises the strobe for one cycle at a time and always draws B at 3 or above with P at 8 or more. Its random settings keep B small, so each period stays within a couple of thousand cycles. The largest B is only checked for validity. The invalid settings are directed cases that each hold long enough to show a silent output.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned MODE_W    = 2;
  localparam int unsigned NUM_MODES = 1 << MODE_W;

  typedef enum logic [MODE_W-1:0] {
    PS_DIV8  = 2'b00,
    PS_DIV16 = 2'b01,
    PS_DIV32 = 2'b10,
    PS_DIV64 = 2'b11
  } psd_mode_e;
endpackage

// File: rtl/psd_cfg_reg.sv
module psd_cfg_reg
  import psd_pkg::*;
#(
  parameter int unsigned A_W      = 6,
  parameter int unsigned B_W      = 13,
  parameter int unsigned B_MIN    = 3,
  parameter logic [A_W-1:0]    RST_A    = '0,
  parameter logic [B_W-1:0]    RST_B    = 13'd8,
  parameter logic [MODE_W-1:0] RST_MODE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [A_W-1:0]    a_i,
  input  logic [B_W-1:0]    b_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [A_W-1:0]    a_o,
  output logic [B_W-1:0]    b_o,
  output psd_mode_e         mode_o,
  output logic              valid_o
);
  localparam int unsigned PAD_W = B_W - A_W;

  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  psd_mode_e      mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= RST_A;
      b_q    <= RST_B;
      mode_q <= psd_mode_e'(RST_MODE);
    end else if (load_i) begin
      a_q    <= a_i;
      b_q    <= b_i;
      mode_q <= psd_mode_e'(mode_i);
    end
  end

  logic [B_W-1:0] a_ext;
  assign a_ext   = {{PAD_W{1'b0}}, a_q};
  assign valid_o = (b_q >= a_ext) && (b_q >= B_W'(B_MIN));
  assign a_o     = a_q;
  assign b_o     = b_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 3,
  parameter int unsigned PC_W      = BASE_LOG2 + NUM_MODES
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      restart_i,
  input  logic      run_i,
  input  psd_mode_e mode_i,
  input  logic      hi_i,
  output logic      tc_o
);
  // last count index per mode for the P and P+1 moduli
  logic [PC_W-1:0] last_lo [NUM_MODES];
  logic [PC_W-1:0] last_hi [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mod
    localparam int unsigned P_VAL = 1 << (BASE_LOG2 + g);
    assign last_lo[g] = PC_W'(P_VAL - 1);
    assign last_hi[g] = PC_W'(P_VAL);
  end

  logic [PC_W-1:0] cnt_q;
  logic [PC_W-1:0] last;

  assign last = hi_i ? last_hi[mode_i] : last_lo[mode_i];
  assign tc_o = run_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= tc_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl #(
  parameter int unsigned    A_W   = 6,
  parameter int unsigned    B_W   = 13,
  parameter logic [A_W-1:0] RST_A = '0,
  parameter logic [B_W-1:0] RST_B = 13'd8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [A_W-1:0] a_new_i,
  input  logic [B_W-1:0] b_new_i,
  input  logic [A_W-1:0] a_cfg_i,
  input  logic [B_W-1:0] b_cfg_i,
  input  logic           run_i,
  input  logic           tc_i,
  output logic           hi_o,
  output logic           end_o
);
  logic [A_W-1:0] a_cnt;
  logic [B_W-1:0] b_cnt;

  assign hi_o  = run_i && (a_cnt != '0);
  assign end_o = tc_i && (b_cnt == B_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_cnt <= RST_A;
      b_cnt <= RST_B;
    end else if (load_i) begin
      a_cnt <= a_new_i;
      b_cnt <= b_new_i;
    end else if (end_o) begin
      a_cnt <= a_cfg_i;
      b_cnt <= b_cfg_i;
    end else if (tc_i) begin
      b_cnt <= b_cnt - 1'b1;
      if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/psd_fb_divider.sv
module psd_fb_divider
  import psd_pkg::*;
#(
  parameter int unsigned A_W       = 6,
  parameter int unsigned B_W       = 13,
  parameter int unsigned BASE_LOG2 = 3,
  parameter int unsigned B_MIN     = 3,
  parameter logic [A_W-1:0]    RST_A    = '0,
  parameter logic [B_W-1:0]    RST_B    = 13'd8,
  parameter logic [MODE_W-1:0] RST_MODE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [A_W-1:0]    a_i,
  input  logic [B_W-1:0]    b_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              load_i,
  output logic              div_o,
  output logic              mod_sel_o,
  output logic              cfg_err_o
);
  localparam int unsigned PC_W = BASE_LOG2 + NUM_MODES;

  logic [A_W-1:0] a_cfg;
  logic [B_W-1:0] b_cfg;
  psd_mode_e      mode_cfg;
  logic           cfg_ok;
  logic           tc, hi, period_end;
  logic           div_q;

  psd_cfg_reg #(
    .A_W(A_W), .B_W(B_W), .B_MIN(B_MIN),
    .RST_A(RST_A), .RST_B(RST_B), .RST_MODE(RST_MODE)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .mode_i (mode_i),
    .a_o    (a_cfg),
    .b_o    (b_cfg),
    .mode_o (mode_cfg),
    .valid_o(cfg_ok)
  );

  psd_prescaler #(.BASE_LOG2(BASE_LOG2), .PC_W(PC_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(load_i),
    .run_i    (cfg_ok),
    .mode_i   (mode_cfg),
    .hi_i     (hi),
    .tc_o     (tc)
  );

  psd_swallow_ctrl #(.A_W(A_W), .B_W(B_W), .RST_A(RST_A), .RST_B(RST_B)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .a_new_i(a_i),
    .b_new_i(b_i),
    .a_cfg_i(a_cfg),
    .b_cfg_i(b_cfg),
    .run_i  (cfg_ok),
    .tc_i   (tc),
    .hi_o   (hi),
    .end_o  (period_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= 1'b0;
    else if (load_i) div_q <= 1'b0;
    else             div_q <= period_end;
  end

  assign div_o     = div_q;
  assign mod_sel_o = hi;
  assign cfg_err_o = ~cfg_ok;
endmodule

// File: rtl/psd_fb_divider_chk.sv
module psd_fb_divider_chk #(
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_W   = 13,
  parameter int unsigned B_MIN = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [A_W-1:0] a_i,
  input logic [B_W-1:0] b_i,
  input logic           load_i,
  input logic           div_o,
  input logic           mod_sel_o,
  input logic           cfg_err_o
);
  logic [B_W-1:0] a_ext;
  logic           new_ok;
  assign a_ext  = B_W'(a_i);
  assign new_ok = (b_i >= a_ext) && (b_i >= B_W'(B_MIN));

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);  // R4
  AST_ERR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !div_o);  // R7
  AST_ERR_NO_MODSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !mod_sel_o);  // R7
  AST_LOAD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !div_o);  // R6
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_err_o));  // R5
  AST_LOAD_VALID_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cfg_err_o == !$past(new_ok)));  // R2
  AST_MODSEL_NO_SWALLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && a_i == '0) |=> !mod_sel_o);  // R9
  AST_MODSEL_SWALLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && a_i != '0 && new_ok) |=> mod_sel_o);  // R9
endmodule

bind psd_fb_divider psd_fb_divider_chk #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .b_i      (b_i),
  .load_i   (load_i),
  .div_o    (div_o),
  .mod_sel_o(mod_sel_o),
  .cfg_err_o(cfg_err_o)
);

// File: tb/tb_psd_fb_divider.sv
`timescale 1ns/1ps
module tb_psd_fb_divider;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  a_i = '0;
  logic [12:0] b_i = '0;
  logic [1:0]  mode_i = '0;
  logic        load_i = 1'b0;
  logic        div_o, mod_sel_o, cfg_err_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  psd_fb_divider dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
    .mode_i(mode_i), .load_i(load_i),
    .div_o(div_o), .mod_sel_o(mod_sel_o), .cfg_err_o(cfg_err_o)
  );

  function automatic int p_of(input int mode);
    return 8 << mode;  // R1
  endfunction

  function automatic int n_of(input int a, input int b, input int mode);
    return p_of(mode) * b + a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // drive a load; returns at the negedge after the load edge
  task automatic do_load(input int a, input int b, input int mode);
    @(negedge clk_i);
    a_i = 6'(a); b_i = 13'(b); mode_i = 2'(mode); load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  // count negedges until div_o is high; also counts mod_sel_o high samples
  task automatic wait_pulse(input int lim, output int cnt, output int hi);
    cnt = 0; hi = 0;
    while (!div_o && cnt < lim) begin
      if (mod_sel_o) hi++;
      @(negedge clk_i);
      cnt++;
    end
  endtask

  task automatic run_cfg(input int a, input int b, input int mode);
    int n, cnt, hi, cnt2, hi2;
    n = n_of(a, b, mode);
    do_load(a, b, mode);
    chk(!div_o, "R6 div low after load", int'(div_o), 0);
    chk(!cfg_err_o, "R2 valid setting flagged", int'(cfg_err_o), 0);
    wait_pulse(n + 200, cnt, hi);
    chk(cnt == n, "R6 first pulse after load", cnt, n);
    chk(hi == a * (p_of(mode) + 1), "R9 modsel cycles", hi, a * (p_of(mode) + 1));
    @(negedge clk_i);
    chk(!div_o, "R4 pulse width", int'(div_o), 0);
    wait_pulse(n + 200, cnt2, hi2);
    chk(cnt2 + 1 == n, "R3 pulse spacing", cnt2 + 1, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL R3 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int cnt, hi, n, a, b, m;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk(!div_o, "R8 div reset", int'(div_o), 0);
    chk(!cfg_err_o, "R8 err reset", int'(cfg_err_o), 0);
    chk(!mod_sel_o, "R8 modsel reset", int'(mod_sel_o), 0);
    rst_ni = 1'b1;
    wait_pulse(300, cnt, hi);
    @(negedge clk_i);
    wait_pulse(300, cnt, hi);
    chk(cnt + 1 == 64, "R8 default period", cnt + 1, 64);

    // R1 each mode, directed corners
    run_cfg(0, 3, 0);
    run_cfg(5, 7, 1);
    run_cfg(30, 30, 3);
    run_cfg(63, 63, 1);
    run_cfg(2, 3, 2);

    // R2 largest counts are valid
    do_load(63, 8191, 3);
    chk(!cfg_err_o, "R2 max setting valid", int'(cfg_err_o), 0);

    // R5 inputs without load have no effect
    run_cfg(5, 10, 1);
    @(negedge clk_i);
    a_i = 6'd1; b_i = 13'd20; mode_i = 2'd3;
    wait_pulse(400, cnt, hi);
    @(negedge clk_i);
    wait_pulse(400, cnt, hi);
    chk(cnt + 1 == n_of(5, 10, 1), "R5 period kept without load", cnt + 1, n_of(5, 10, 1));
    chk(!cfg_err_o, "R5 flag kept without load", int'(cfg_err_o), 0);

    // R7 invalid settings
    do_load(6, 5, 0);
    chk(cfg_err_o, "R7 B<A flagged", int'(cfg_err_o), 1);
    hi = 0;
    for (int i = 0; i < 500; i++) begin
      if (div_o || mod_sel_o) hi++;
      @(negedge clk_i);
    end
    chk(hi == 0, "R7 silent B<A", hi, 0);
    do_load(0, 2, 1);
    chk(cfg_err_o, "R7 B<3 flagged", int'(cfg_err_o), 1);
    hi = 0;
    for (int i = 0; i < 500; i++) begin
      if (div_o || mod_sel_o) hi++;
      @(negedge clk_i);
    end
    chk(hi == 0, "R7 silent B<3", hi, 0);
    run_cfg(4, 9, 0);

    // R3 random settings
    for (int k = 0; k < 12; k++) begin
      m = int'($urandom % 4);
      b = 3 + int'($urandom % 28);
      a = int'($urandom % (b + 1));
      run_cfg(a, b, m);
    end
    n = checks;
    finish_run();
  end
endmodule